// File: doc/BRIEF.md
# Opcode-Selected 16-bit Integer ALU

This block is the combinational arithmetic and logic stage of a small 16-bit core. A 4-bit opcode selects one of eight register-to-register operations. Both operands are 16-bit words: the left one comes from the first source register and the right one from the second. The supported operations are add, subtract, AND, OR, NAND, XOR, zero-filling left shift and sign-filling right shift. Any other opcode value drives the main result to zero.

Two more datapaths serve the immediate-load instructions. The first widens an 8-bit immediate to a full word by sign extension. The second writes the immediate into the high byte of a word and keeps the low byte of the destination register's present value.

A third datapath reports three condition flags for an operand that the core chooses: negative, zero and positive. Branch logic uses these flags.

The block holds no state and has no handshake. Each output is a pure function of the inputs that feed it. There is no carry or overflow output.

Top module: `opc_alu`

## Requirements
- R1: Opcode 0x0 gives (lhs + rhs) mod 2^16 and opcode 0x1 gives (lhs - rhs) mod 2^16; wrap-around raises no extra output.
- R2: Opcodes 0x2, 0x3, 0x4 and 0x5 give the bitwise AND, OR, NAND and XOR of lhs and rhs. NAND with equal operands yields the bitwise NOT of the operand.
- R3: Opcode 0x6 gives lhs shifted left by the unsigned value of rhs, with zeros filling the low bits.
- R4: Opcode 0x7 gives lhs shifted right by the unsigned value of rhs, with copies of lhs bit 15 filling the high bits.
- R5: When rhs is 16 or larger, opcode 0x6 gives 0x0000, and opcode 0x7 gives 0xFFFF if lhs bit 15 is set and 0x0000 if it is clear.
- R6: The sign-extend output equals imm_i in bits 7..0, and each of bits 15..8 equals imm_i bit 7.
- R7: The merge output equals imm_i in bits 15..8 and cur_i bits 7..0 in bits 7..0.
- R8: For cond_opnd_i taken as two's complement, neg_o is set exactly when bit 15 is 1, zero_o exactly when all bits are 0, and pos_o otherwise. Exactly one of the three flags is set.
- R9: Opcodes 0x8 to 0xF drive res_o to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select |
| lhs_i | input | 16 | Left operand |
| rhs_i | input | 16 | Right operand; also the shift amount |
| imm_i | input | 8 | Byte immediate |
| cur_i | input | 16 | Present destination value for the merge path |
| cond_opnd_i | input | 16 | Operand whose sign class is reported |
| res_o | output | 16 | Result of the selected operation |
| sext_o | output | 16 | Sign-extended immediate |
| merge_o | output | 16 | Immediate merged into the high byte |
| neg_o | output | 1 | Operand is negative |
| zero_o | output | 1 | Operand is zero |
| pos_o | output | 1 | Operand is positive |

## Verification
The bench builds the block with its default parameters: a 16-bit word and an 8-bit immediate. With these values a shift amount of exactly 16 is reachable, and so is an amount whose only set bit lies above the low four bits. These cases test the saturation rule of R5 rather than a truncated shift count. The 8-bit immediate makes the bit-7 sign boundary of R6 directly testable, using the values 0x7F and 0x80.

// File: rtl/opc_alu_pkg.sv
package opc_alu_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 4'h0,
    OPC_SUB  = 4'h1,
    OPC_AND  = 4'h2,
    OPC_OR   = 4'h3,
    OPC_NAND = 4'h4,
    OPC_XOR  = 4'h5,
    OPC_SLL  = 4'h6,
    OPC_SRA  = 4'h7
  } alu_opc_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } sign_flags_t;
endpackage

// File: rtl/opc_alu_arith.sv
module opc_alu_arith #(
  parameter int W = 16
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] b_eff;

  // Subtraction is addition of the inverted right operand plus one.
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    y_o   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  end
endmodule

// File: rtl/opc_alu_logic.sv
module opc_alu_logic #(
  parameter int W = 16
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  // sel: 0 = AND, 1 = OR, 2 = NAND, 3 = XOR
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = ~(a_i & b_i);
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/opc_alu_shift.sv
module opc_alu_shift #(
  parameter int W = 16
) (
  input  logic         right_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] amt_i,
  output logic [W-1:0] y_o
);
  localparam int SH_W = $clog2(W);

  logic            over;
  logic [SH_W-1:0] sh;
  logic            fill;

  always_comb begin
    // Any set bit at or above position SH_W means the amount is at least W.
    over = |amt_i[W-1:SH_W];
    sh   = amt_i[SH_W-1:0];
    fill = a_i[W-1];
    if (right_i) begin
      if (over) y_o = {W{fill}};
      else      y_o = W'($signed(a_i) >>> sh);
    end else begin
      if (over) y_o = '0;
      else      y_o = a_i << sh;
    end
  end
endmodule

// File: rtl/opc_alu_imm.sv
module opc_alu_imm #(
  parameter int W     = 16,
  parameter int IMM_W = 8
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [W-1:0]     cur_i,
  output logic [W-1:0]     sext_o,
  output logic [W-1:0]     merge_o
);
  localparam int HI_W = W - IMM_W;

  always_comb begin
    sext_o  = {{HI_W{imm_i[IMM_W-1]}}, imm_i};
    merge_o = {imm_i, cur_i[HI_W-1:0]};
  end
endmodule

// File: rtl/opc_alu.sv
module opc_alu
  import opc_alu_pkg::*;
#(
  parameter int W     = 16,
  parameter int IMM_W = 8
) (
  input  logic [OPC_W-1:0] op_i,
  input  logic [W-1:0]     lhs_i,
  input  logic [W-1:0]     rhs_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [W-1:0]     cur_i,
  input  logic [W-1:0]     cond_opnd_i,
  output logic [W-1:0]     res_o,
  output logic [W-1:0]     sext_o,
  output logic [W-1:0]     merge_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             pos_o
);
  logic [W-1:0] arith_y, logic_y, shift_y;
  logic [1:0]   logic_sel;
  sign_flags_t  flags;

  // Logic unit ordering: AND, OR, NAND, XOR follow opcodes 2..5.
  assign logic_sel = 2'(op_i - OPC_AND);

  opc_alu_arith #(.W(W)) u_arith (
    .sub_i (op_i == OPC_SUB),
    .a_i   (lhs_i),
    .b_i   (rhs_i),
    .y_o   (arith_y)
  );

  opc_alu_logic #(.W(W)) u_logic (
    .sel_i (logic_sel),
    .a_i   (lhs_i),
    .b_i   (rhs_i),
    .y_o   (logic_y)
  );

  opc_alu_shift #(.W(W)) u_shift (
    .right_i (op_i == OPC_SRA),
    .a_i     (lhs_i),
    .amt_i   (rhs_i),
    .y_o     (shift_y)
  );

  opc_alu_imm #(.W(W), .IMM_W(IMM_W)) u_imm (
    .imm_i   (imm_i),
    .cur_i   (cur_i),
    .sext_o  (sext_o),
    .merge_o (merge_o)
  );

  always_comb begin
    unique case (op_i)
      OPC_ADD, OPC_SUB:                   res_o = arith_y;
      OPC_AND, OPC_OR, OPC_NAND, OPC_XOR: res_o = logic_y;
      OPC_SLL, OPC_SRA:                   res_o = shift_y;
      default:                            res_o = '0;
    endcase
  end

  always_comb begin
    flags.neg  = cond_opnd_i[W-1];
    flags.zero = (cond_opnd_i == '0);
    flags.pos  = ~flags.neg & ~flags.zero;
  end

  assign neg_o  = flags.neg;
  assign zero_o = flags.zero;
  assign pos_o  = flags.pos;
endmodule

// File: rtl/opc_alu_chk.sv
module opc_alu_chk #(
  parameter int W     = 16,
  parameter int IMM_W = 8
) (
  input logic [3:0]       op_i,
  input logic [W-1:0]     lhs_i,
  input logic [W-1:0]     rhs_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [W-1:0]     cur_i,
  input logic [W-1:0]     cond_opnd_i,
  input logic [W-1:0]     res_o,
  input logic [W-1:0]     sext_o,
  input logic [W-1:0]     merge_o,
  input logic             neg_o,
  input logic             zero_o,
  input logic             pos_o
);
  localparam int HI_W = W - IMM_W;

  always_comb begin
    if (op_i == 4'h4 && lhs_i == rhs_i)
      assert_nand_not_R2: assert (res_o == ~lhs_i);
    if (op_i == 4'h6 && rhs_i >= W[W-1:0])
      assert_sll_sat_R5: assert (res_o == '0);
    if (op_i == 4'h7 && rhs_i >= W[W-1:0])
      assert_sra_sat_R5: assert (res_o == {W{lhs_i[W-1]}});
    assert_sext_fill_R6: assert (sext_o[W-1:IMM_W] == {HI_W{imm_i[IMM_W-1]}});
    assert_merge_low_R7: assert (merge_o[HI_W-1:0] == cur_i[HI_W-1:0]
                                 && merge_o[W-1:HI_W] == imm_i);
    assert_flag_onehot_R8: assert ($onehot({neg_o, zero_o, pos_o}));
    assert_neg_sign_R8: assert (neg_o == cond_opnd_i[W-1]);
    if (op_i[3])
      assert_unused_zero_R9: assert (res_o == '0);
  end
endmodule

bind opc_alu opc_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .op_i(op_i), .lhs_i(lhs_i), .rhs_i(rhs_i), .imm_i(imm_i), .cur_i(cur_i),
  .cond_opnd_i(cond_opnd_i), .res_o(res_o), .sext_o(sext_o),
  .merge_o(merge_o), .neg_o(neg_o), .zero_o(zero_o), .pos_o(pos_o)
);

// File: tb/sim_opc_alu.sv
`timescale 1ns/1ps
module sim_opc_alu;
  localparam int W = 16;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]   op;
  logic [W-1:0] lhs, rhs, cur, copnd, res, sext, merge;
  logic [7:0]   imm;
  logic         neg, zero, pos;

  int n_chk = 0;
  int n_bad = 0;

  opc_alu u0 (
    .op_i(op), .lhs_i(lhs), .rhs_i(rhs), .imm_i(imm), .cur_i(cur),
    .cond_opnd_i(copnd), .res_o(res), .sext_o(sext), .merge_o(merge),
    .neg_o(neg), .zero_o(zero), .pos_o(pos)
  );

  // {op, lhs, rhs, expected}
  localparam logic [51:0] VEC [NV] = '{
    {4'h0, 16'h0001, 16'h0002, 16'h0003},
    {4'h0, 16'hFFFF, 16'h0001, 16'h0000},
    {4'h1, 16'h0005, 16'h0007, 16'hFFFE},
    {4'h2, 16'hF0F0, 16'hFF00, 16'hF000},
    {4'h3, 16'hF0F0, 16'h0F00, 16'hFFF0},
    {4'h4, 16'hF0F0, 16'hFF00, 16'h0FFF},
    {4'h5, 16'hAAAA, 16'hFFFF, 16'h5555},
    {4'h6, 16'h0001, 16'h0004, 16'h0010},
    {4'h6, 16'h8001, 16'h000F, 16'h8000},
    {4'h6, 16'h1234, 16'h0010, 16'h0000},
    {4'h7, 16'h8000, 16'h0001, 16'hC000},
    {4'h7, 16'h7F00, 16'h0004, 16'h07F0},
    {4'h7, 16'h8000, 16'h0100, 16'hFFFF},
    {4'h7, 16'h4000, 16'h0014, 16'h0000},
    {4'h0D, 16'h1234, 16'h5678, 16'h0000}
  };

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic flags_chk(input logic [W-1:0] v, input logic [2:0] exp);
    @(negedge clk);
    copnd = v;
    #1;
    check("R8", {13'd0, neg, zero, pos}, {13'd0, exp});
  endtask

  function automatic string tag_of(input logic [3:0] o, input logic [W-1:0] r);
    if (o[3]) return "R9";
    if (o <= 4'h1) return "R1";
    if (o <= 4'h5) return "R2";
    if (r >= 16'd16) return "R5";
    if (o == 4'h6) return "R3";
    return "R4";
  endfunction

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    op = 4'h0; lhs = '0; rhs = '0; imm = '0; cur = '0; copnd = '0;
    repeat (2) @(negedge clk);
    #1;
    // reset state with all-zero inputs: zero result and zero flag (R1, R8)
    check("R1", res, 16'h0000);
    check("R8", {13'd0, neg, zero, pos}, 16'h0002);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, lhs, rhs} = VEC[i][51:16];
      #1;
      check(tag_of(op, rhs), res, VEC[i][15:0]);
    end

    // R2: NAND of an operand with itself is NOT
    @(negedge clk);
    op = 4'h4; lhs = 16'h1234; rhs = 16'h1234;
    #1;
    check("R2", res, 16'hEDCB);

    // R6: sign extension at the bit-7 boundary
    @(negedge clk);
    imm = 8'h80; cur = 16'h1234;
    #1;
    check("R6", sext, 16'hFF80);
    check("R7", merge, 16'h8034);
    @(negedge clk);
    imm = 8'h7F;
    #1;
    check("R6", sext, 16'h007F);
    @(negedge clk);
    imm = 8'hAB; cur = 16'h12CD;
    #1;
    check("R7", merge, 16'hABCD);

    // R8 flags: {neg, zero, pos}
    flags_chk(16'h8000, 3'b100);
    flags_chk(16'h0000, 3'b010);
    flags_chk(16'h0001, 3'b001);
    flags_chk(16'h7FFF, 3'b001);
    flags_chk(16'hFFFF, 3'b100);

    // R9: top opcode
    @(negedge clk);
    op = 4'hF; lhs = 16'hFFFF; rhs = 16'hFFFF;
    #1;
    check("R9", res, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule